// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shared table of two-bit saturating counters and a global shift register of recent branch outcomes. A counter is selected by XORing that outcome history with a slice of the branch address. The same branch can therefore use a different counter for each path that leads to it. Different branches reaching a similar path share counters, and their training can interfere.

The fetch side presents a lookup address and reads the prediction combinationally in the same cycle. The execute side reports each resolved branch by driving its address and actual direction with a valid strobe. On that clock edge the counter chosen by the history in place before the edge is trained, and then the outcome is shifted into the history. Nothing is speculative: the history only moves when a branch resolves.

Top module: `gshare_predictor`

## Requirements
- R1: A synchronous active-high reset clears the history to all zeros and every counter to the strongly-not-taken value 00. After reset, every lookup address predicts not taken.
- R2: Each resolve shifts its outcome into history bit 0 (1 = taken, 0 = not taken). Older bits move one place toward the MSB, and bit HIST_W-1 is discarded.
- R3: The table index is address bits [PC_LSB+HIST_W-1:PC_LSB] XOR the history. Address bits outside that slice have no effect on which counter is used (defaults: bits [9:2], HIST_W=8).
- R4: Each counter saturates: a taken resolve increments it up to a ceiling of 11, and a not-taken resolve decrements it down to a floor of 00. Values 10 and 11 predict taken, and values 00 and 01 predict not taken.
- R5: A resolve trains the counter indexed with the history value held before that resolve's own outcome is shifted in.
- R6: A lookup in the same cycle as a resolve sees the counter and history values from before that resolve's update.
- R7: When the resolve strobe is low, neither the history nor any counter changes, whatever is on the other resolve inputs.
- R8: All branches share one table of 2^HIST_W counters. Two address/history pairs that produce the same index read and train the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| lkp_pc | input | ADDR_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction for lkp_pc (1 = taken), combinational |
| rsv_valid | input | 1 | A branch resolves this cycle |
| rsv_pc | input | ADDR_W | Address of the resolving branch |
| rsv_taken | input | 1 | Actual direction of the resolving branch (1 = taken) |

## Verification
The hardest state to reach from the ports is one chosen counter being stepped through its whole saturation range. Every resolve moves the history, so a fixed address keeps landing on different counters. The bench works around this by tracking the history in its model and computing, before each resolve, an address whose index slice XORed with that history hits the wanted counter. The upper and lowest address bits are random, so the same targeting also shows that the bits outside the slice are ignored and that differently addressed branches alias onto one entry. A short directed prologue fixes the shift direction by loading a known pattern and then looking up the one address whose index only lines up if bit 0 received the newest outcome.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_predicts(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gs_history.sv
module gs_history
    import gshare_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  outcome_t          upd_i,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (upd_i.valid) begin
            hist_q <= {hist_q[HIST_W-2:0], upd_i.taken};
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/gs_index_hash.sv
module gs_index_hash #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 8,
    parameter int PC_LSB = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [HIST_W-1:0] hist_i,
    output logic [HIST_W-1:0] idx_o
);

    assign idx_o = pc_i[PC_LSB +: HIST_W] ^ hist_i;

endmodule

// File: rtl/gs_counter_table.sv
module gs_counter_table
    import gshare_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic               wr_taken_i,
    output logic [2*DEPTH-1:0] state_o
);

    ctr_e tbl_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit;
        assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_q[e] <= CTR_STRONG_NT;
            end else if (hit) begin
                tbl_q[e] <= ctr_next(tbl_q[e], wr_taken_i);
            end
        end

        assign state_o[2*e +: 2] = tbl_q[e];
    end

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 8,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lkp_pc,
    output logic              pred_taken,
    input  logic              rsv_valid,
    input  logic [ADDR_W-1:0] rsv_pc,
    input  logic              rsv_taken
);

    localparam int DEPTH = 1 << HIST_W;

    outcome_t            rsv_out;
    logic [HIST_W-1:0]   hist_q;
    logic [HIST_W-1:0]   lkp_idx;
    logic [HIST_W-1:0]   rsv_idx;
    logic [2*DEPTH-1:0]  tbl_state;
    ctr_e                lkp_ctr;

    assign rsv_out.valid = rsv_valid;
    assign rsv_out.taken = rsv_taken;

    gs_history #(.HIST_W(HIST_W)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (rsv_out),
        .hist_o (hist_q)
    );

    gs_index_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) u_lkp_hash (
        .pc_i   (lkp_pc),
        .hist_i (hist_q),
        .idx_o  (lkp_idx)
    );

    gs_index_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) u_rsv_hash (
        .pc_i   (rsv_pc),
        .hist_i (hist_q),
        .idx_o  (rsv_idx)
    );

    gs_counter_table #(.IDX_W(HIST_W)) u_tbl (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (rsv_valid),
        .wr_idx_i   (rsv_idx),
        .wr_taken_i (rsv_taken),
        .state_o    (tbl_state)
    );

    assign lkp_ctr    = ctr_e'(tbl_state[2*lkp_idx +: 2]);
    assign pred_taken = ctr_predicts(lkp_ctr);

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 8,
    parameter int PC_LSB = 2,
    localparam int DEPTH = 1 << HIST_W
) (
    input logic               clk,
    input logic               rst,
    input logic               rsv_valid,
    input logic [ADDR_W-1:0]  rsv_pc,
    input logic               rsv_taken,
    input logic [HIST_W-1:0]  hist,
    input logic [2*DEPTH-1:0] tbl_state
);

    logic [HIST_W-1:0] widx;
    logic [1:0]        wold;
    logic [1:0]        wexp;
    logic [HIST_W-1:0] widx_d;
    logic [1:0]        wexp_d;
    logic              wvld_d;

    always_comb begin
        widx = rsv_pc[PC_LSB +: HIST_W] ^ hist;
        wold = tbl_state[2*widx +: 2];
        if (rsv_taken) wexp = (wold == 2'd3) ? 2'd3 : wold + 2'd1;
        else           wexp = (wold == 2'd0) ? 2'd0 : wold - 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            widx_d <= '0;
            wexp_d <= '0;
            wvld_d <= 1'b0;
        end else begin
            widx_d <= widx;
            wexp_d <= wexp;
            wvld_d <= rsv_valid;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (hist == '0) && (tbl_state == '0)); // R1

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        rsv_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(rsv_taken)}); // R2

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wvld_d |-> tbl_state[2*widx_d +: 2] == wexp_d); // R4 R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rsv_valid |=> $stable(hist) && $stable(tbl_state)); // R7

endmodule

bind gshare_predictor gshare_predictor_chk #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rsv_valid (rsv_valid),
    .rsv_pc    (rsv_pc),
    .rsv_taken (rsv_taken),
    .hist      (hist_q),
    .tbl_state (tbl_state)
);

// File: tb/gshare_predictor_tb_top.sv
`timescale 1ns/1ps
module gshare_predictor_tb_top;

    localparam int AW = 32;
    localparam int HW = 8;
    localparam int LSB = 2;
    localparam int NENT = 1 << HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lkp_pc = '0;
    logic          pred_taken;
    logic          rsv_valid = 1'b0;
    logic [AW-1:0] rsv_pc = '0;
    logic          rsv_taken = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    int          m_ctr [NENT];
    logic [HW-1:0] m_hist;

    always #2.5 clk = ~clk;

    gshare_predictor #(.ADDR_W(AW), .HIST_W(HW), .PC_LSB(LSB)) dut_i (
        .clk(clk), .rst(rst), .lkp_pc(lkp_pc), .pred_taken(pred_taken),
        .rsv_valid(rsv_valid), .rsv_pc(rsv_pc), .rsv_taken(rsv_taken)
    );

    function automatic logic [AW-1:0] pc_for(input logic [HW-1:0] idx);
        logic [AW-1:0] p;
        p = AW'($urandom);
        p[LSB +: HW] = idx ^ m_hist;
        return p;
    endfunction

    function automatic logic model_pred(input logic [AW-1:0] pc);
        return m_ctr[pc[LSB +: HW] ^ m_hist] >= 2;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NENT; i++) m_ctr[i] = 0;
        m_hist = '0;
    endtask

    task automatic model_update(input logic [AW-1:0] pc, input logic t);
        int k;
        k = int'(pc[LSB +: HW] ^ m_hist);
        if (t) begin
            if (m_ctr[k] < 3) m_ctr[k]++;
        end else begin
            if (m_ctr[k] > 0) m_ctr[k]--;
        end
        m_hist = {m_hist[HW-2:0], t};
    endtask

    // want < 0: expected value from the model; otherwise the given bit
    task automatic cyc(input logic [AW-1:0] lpc, input logic v, input logic [AW-1:0] rpc,
                       input logic t, input int want, input string tag);
        logic exp;
        @(negedge clk);
        lkp_pc = lpc; rsv_valid = v; rsv_pc = rpc; rsv_taken = t;
        #1;
        exp = (want < 0) ? model_pred(lpc) : logic'(want);
        n_chk++;
        if (pred_taken !== exp) begin
            n_err++;
            $display("FAIL %s: pred_taken actual=%b expected=%b (lkp_pc=%h)", tag, pred_taken, exp, lpc);
        end
        @(posedge clk);
        if (v) model_update(rpc, t);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    localparam logic [HW-1:0] K = 8'hA5;
    logic trace_t [15] = '{1,1,1,1,1,0,1,1,1,1,0,1,0,0,0};
    logic trace_p [15] = '{0,0,1,1,1,1,1,1,1,1,1,1,1,1,0};

    initial begin
        logic [AW-1:0] a;
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: everything predicts not taken after reset
        for (int i = 0; i < 4; i++) cyc(AW'($urandom), 0, '0, 0, 0, "R1");

        // R2 R5: fix shift direction and pre-shift indexing
        for (int i = 0; i < 8; i++) cyc('0, 1, '0, 0, -1, "R2");
        cyc('0, 1, AW'(0), 1, 0, "R5");           // ctr[0]=1, hist=01
        cyc('0, 1, AW'(8'h01) << LSB, 1, 0, "R5"); // idx 01^01=0 -> ctr[0]=2, hist=03
        cyc(AW'(8'h03) << LSB, 0, '0, 0, 1, "R2");
        cyc(AW'(8'h03) << LSB | 32'hFFFF_FC03, 0, '0, 0, 1, "R3");

        // R4 R6 R8: full saturation trace on counter K, lookup and resolve same cycle
        for (int i = 0; i < 15; i++) begin
            a = pc_for(K);
            cyc(a, 1, pc_for(K), trace_t[i], int'(trace_p[i]), "R4");
        end
        cyc(pc_for(K), 0, '0, 0, 0, "R8");

        // R7: train K to taken, then strobe low with busy resolve inputs
        for (int i = 0; i < 3; i++) cyc(pc_for(K), 1, pc_for(K), 1, -1, "R6");
        for (int i = 0; i < 6; i++) cyc(pc_for(K), 0, AW'($urandom), 1'($urandom), 1, "R7");
        for (int i = 0; i < 6; i++) cyc(pc_for(K), 0, AW'($urandom), 0, 1, "R7");

        // R3 R8: random addresses aliasing onto K predict alike
        for (int i = 0; i < 4; i++) cyc(pc_for(K), 0, '0, 0, 1, "R8");

        // Random mix with a small hot index set to provoke aliasing
        for (int i = 0; i < 4000; i++) begin
            logic [HW-1:0] li, ri;
            li = ($urandom % 4 == 0) ? HW'($urandom) : HW'($urandom % 6);
            ri = ($urandom % 4 == 0) ? HW'($urandom) : HW'($urandom % 6);
            cyc(pc_for(li), 1'($urandom % 5 != 0), pc_for(ri), 1'($urandom % 3 != 0), -1, "R6");
        end

        // R1: reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) cyc(AW'($urandom), 0, '0, 0, 0, "R1");

        finish_run();
    end

endmodule